// File: doc/BRIEF.md
# Watch Timer With Buzzer and Display Clock

This block is a slow-clock timer that runs on a 32.768 kHz subsystem clock. A single 14-bit divider chain is the source for everything the block produces. It raises a sticky interval flag once per half second in normal mode, or once every 128 input cycles in fast mode. It drives a square wave at one of four audio frequencies onto a buzzer pin. It also provides a fixed 512 Hz clock to the display refresh logic.

Software sets the block up through a single control register write. It then waits for the interval flag and acknowledges it with a clear pulse. A mode change written in the middle of an interval waits until the divider wraps, so the interval in progress is never cut short. The block has no streaming data path, so every pin is plain control or status and there is no back-pressure to handle.

Top module: `watch_timer`

## Requirements
- R1: After reset, irq_flag, buzz_o and disp_clk are all 0, and the control register holds zero, which means the block is disabled.
- R2: A write is taken on a rising edge where cfg_we is 1. The fields of cfg_wdata are: bit 0 enable, bit 1 fast mode, bit 2 buzzer enable, and bits 4:3 buzzer select. A write replaces the whole register at that edge.
- R3: In normal mode, irq_flag rises exactly 16384 cycles after the edge that wrote enable=1. It rises again every 16384 cycles after that.
- R4: In fast mode, irq_flag rises every 128 cycles, counted from the edge that enabled the block.
- R5: irq_flag stays at 1 until a cycle in which irq_clr is 1. A clear with no coinciding terminal count drops the flag at the next edge.
- R6: When irq_clr arrives in the same cycle as a terminal count, the flag stays at 1.
- R7: With buzzer enable set, buzz_o is a square wave that starts low. Buzzer select 0, 1, 2 and 3 give half-periods of 8, 4, 2 and 1 cycles respectively, which are 2, 4, 8 and 16 kHz. With buzzer enable clear, buzz_o stays at 0.
- R8: While enabled, disp_clk is a square wave with a period of 64 cycles (512 Hz). It is low for the first 32 cycles after enable.
- R9: Clearing enable returns the divider to zero, holds buzz_o and disp_clk at 0, and produces no interval events. Enabling again starts a full interval from zero.
- R10: A mode bit written while the block is enabled takes effect only at the next wrap of the whole 14-bit divider. Until that wrap, ticks follow the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz subsystem clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control word: enable, fast, buzzer enable, buzzer select |
| irq_clr | input | 1 | Clears the interval flag |
| irq_flag | output | 1 | Sticky interval request flag |
| buzz_o | output | 1 | Buzzer square-wave output |
| disp_clk | output | 1 | 512 Hz clock for display refresh |

## Verification
The bench switches from normal to fast mode in the middle of an interval. A design that switched at once would raise fast-mode flags early, and the scoreboard rejects them as unexpected. It issues a clear in exactly the cycle of a terminal count; if the clear won that race, the request would be silently lost. It disables and re-enables the block, which catches a divider that kept its old count and so gave a short first interval. It also measures the first edge of each buzzer tap and of the display clock, which exposes a select field wired in reverse or a tap one bit off.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CTRL_W = 5;
  localparam int SEL_W  = 2;

  typedef struct packed {
    logic [SEL_W-1:0] buz_sel;
    logic             buz_en;
    logic             fast;
    logic             en;
  } wt_ctrl_t;
endpackage

// File: rtl/wt_ctrl_reg.sv
module wt_ctrl_reg
  import wt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  wt_ctrl_t wdata,
  input  logic     wrap,
  output wt_ctrl_t ctrl,
  output logic     mode_fast
);
  logic next_fast;

  assign next_fast = we ? wdata.fast : ctrl.fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (we) begin
      ctrl <= wdata;
    end
  end

  // active mode follows the register only while idle or at a full wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_fast <= 1'b0;
    end else if (!ctrl.en || wrap) begin
      mode_fast <= next_fast;
    end
  end
endmodule

// File: rtl/wt_divider.sv
module wt_divider #(
  parameter int CNT_W  = 14,
  parameter int FAST_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_fast,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             wrap
);
  logic full_end;
  logic fast_end;

  assign full_end = (cnt == {CNT_W{1'b1}});
  assign fast_end = (cnt[FAST_W-1:0] == {FAST_W{1'b1}});
  assign wrap     = en & full_end;
  assign tick     = en & (mode_fast ? fast_end : full_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wt_flag.sv
module wt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else begin
      flag <= set | (flag & ~clr);
    end
  end
endmodule

// File: rtl/wt_taps.sv
module wt_taps #(
  parameter int CNT_W    = 14,
  parameter int SEL_W    = 2,
  parameter int BUZ_TOP  = 3,
  parameter int DISP_TAP = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic             buz_en,
  input  logic [SEL_W-1:0] sel,
  output logic             buzz,
  output logic             disp
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] tap_v;

  // select 0 takes the slowest tap, and each step up halves the period
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign tap_v[g] = cnt[BUZ_TOP-g];
  end

  assign buzz = en & buz_en & tap_v[sel];
  assign disp = en & cnt[DISP_TAP];
endmodule

// File: rtl/watch_timer.sv
module watch_timer
  import wt_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int FAST_W   = 7,
  parameter int BUZ_TOP  = 3,
  parameter int DISP_TAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              irq_clr,
  output logic              irq_flag,
  output logic              buzz_o,
  output logic              disp_clk
);
  wt_ctrl_t         ctrl;
  wt_ctrl_t         wdata_s;
  logic             mode_fast;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             wrap;

  assign wdata_s = wt_ctrl_t'(cfg_wdata);

  wt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(wdata_s),
    .wrap(wrap), .ctrl(ctrl), .mode_fast(mode_fast)
  );

  wt_divider #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .mode_fast(mode_fast),
    .cnt(cnt), .tick(tick), .wrap(wrap)
  );

  wt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(tick), .clr(irq_clr), .flag(irq_flag)
  );

  wt_taps #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BUZ_TOP(BUZ_TOP), .DISP_TAP(DISP_TAP)) u_taps (
    .cnt(cnt), .en(ctrl.en), .buz_en(ctrl.buz_en), .sel(ctrl.buz_sel),
    .buzz(buzz_o), .disp(disp_clk)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             buz_en_q,
  input logic             mode_fast,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             wrap,
  input logic             irq_clr,
  input logic             irq_flag,
  input logic             buzz_o,
  input logic             disp_clk
);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tick) |=> !irq_flag);

  assert_tick_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> irq_flag);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!buzz_o && !disp_clk && !tick));

  assert_buzz_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !buz_en_q |-> !buzz_o);

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wrap) |=> (mode_fast == $past(mode_fast)));
endmodule

bind watch_timer wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(ctrl.en), .buz_en_q(ctrl.buz_en),
  .mode_fast(mode_fast), .cnt(cnt), .tick(tick), .wrap(wrap),
  .irq_clr(irq_clr), .irq_flag(irq_flag), .buzz_o(buzz_o), .disp_clk(disp_clk)
);

// File: tb/sim_watch_timer.sv
`timescale 1ns/1ps
module sim_watch_timer;
  typedef struct {
    int    at;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       irq_clr = 1'b0;
  logic       irq_flag, buzz_o, disp_clk;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_errors = 0;
  exp_t exp_q[$];
  logic prev_flag = 1'b0;
  bit   done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  watch_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .buzz_o(buzz_o), .disp_clk(disp_clk)
  );

  task automatic check(input string tag, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, expv);
    end
  endtask

  task automatic write_cfg(input logic [4:0] d, output int c);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    c = cyc;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_rise(input int t, input string tag);
    exp_t e;
    e.at = t;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: every flag rise is matched against the next expected item
  always @(negedge clk) begin
    if (rst_n && irq_flag && !prev_flag) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R3/R4/R10 unexpected flag rise at cycle %0d expected none", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.at != cyc) begin
          n_errors++;
          $display("FAIL %s flag rise at cycle %0d expected %0d", e.tag, cyc, e.at);
        end
      end
    end
    prev_flag = irq_flag;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2, t0;
    repeat (3) @(negedge clk);
    check("R1 flag", irq_flag, 1'b0);
    check("R1 buzz", buzz_o, 1'b0);
    check("R1 disp", disp_clk, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle flag", irq_flag, 1'b0);
    check("R1 idle disp", disp_clk, 1'b0);

    // R2/R3: normal mode enable
    write_cfg(5'b00001, c0);
    expect_rise(c0 + 16384, "R3 first normal interval");
    wait_to(c0 + 31);  check("R8 disp low half", disp_clk, 1'b0);
    wait_to(c0 + 32);  check("R8 disp high half", disp_clk, 1'b1);
    wait_to(c0 + 64);  check("R8 disp period", disp_clk, 1'b0);
    wait_to(c0 + 16384 + 3);
    check("R5 flag held", irq_flag, 1'b1);
    pulse_clr();
    check("R5 flag cleared", irq_flag, 1'b0);

    // R10: fast mode requested mid-interval
    write_cfg(5'b00011, c1);
    expect_rise(c0 + 32768, "R10 pending switch keeps normal interval");
    expect_rise(c0 + 32768 + 128, "R4 first fast interval");
    wait_to(c0 + 32768 + 2);
    pulse_clr();
    t0 = c0 + 32768 + 128;
    wait_to(t0 + 2);
    pulse_clr();

    // R6: clear in the terminal-count cycle
    expect_rise(t0 + 128, "R4 fast interval");
    wait_to(t0 + 255);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R6 coincident clear keeps flag", irq_flag, 1'b1);
    wait_to(t0 + 260);
    pulse_clr();
    check("R5 clear after coincidence", irq_flag, 1'b0);
    expect_rise(t0 + 384, "R4 fast period");
    wait_to(t0 + 386);
    pulse_clr();

    // R9: disable
    write_cfg(5'b00000, c2);
    check("R9 disp held low", disp_clk, 1'b0);
    wait_to(c2 + 300);
    check("R9 no events while off", irq_flag, 1'b0);

    // R7: buzzer taps, each from a fresh divider
    for (int s = 0; s < 4; s++) begin
      int c, hb;
      write_cfg(5'b00000, c);
      write_cfg({s[1:0], 3'b101}, c);
      hb = 1 << (3 - s);
      wait_to(c + hb - 1); check($sformatf("R7 sel%0d low half", s), buzz_o, 1'b0);
      wait_to(c + hb);     check($sformatf("R7 sel%0d high half", s), buzz_o, 1'b1);
      wait_to(c + 2*hb);   check($sformatf("R7 sel%0d period", s), buzz_o, 1'b0);
    end
    write_cfg(5'b00000, c2);
    write_cfg(5'b11001, c2);
    wait_to(c2 + 1);
    check("R7 buzzer disabled", buzz_o, 1'b0);

    // R9: disable forces buzzer low, re-enable restarts interval
    write_cfg(5'b00000, c2);
    write_cfg(5'b11101, c2);
    wait_to(c2 + 1);
    check("R7 16k tap running", buzz_o, 1'b1);
    wait_to(c2 + 40);
    write_cfg(5'b00000, c2);
    check("R9 buzz forced low", buzz_o, 1'b0);
    check("R9 disp forced low", disp_clk, 1'b0);
    write_cfg(5'b00011, c2);
    expect_rise(c2 + 128, "R9 restart from zero");
    wait_to(c2 + 131);
    pulse_clr();
    write_cfg(5'b00000, c2);
    wait_to(c2 + 10);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R3/R4 missing flag rises: %0d outstanding expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule